// File: doc/BRIEF.md
# Padded Rate-Block Builder for an Extendable-Output Hash

This block turns a message made of a 32-byte secret seed followed by a ciphertext of run-time length into the sequence of padded 136-byte rate blocks that an extendable-output sponge absorbs. The seed arrives on a parallel input. The ciphertext is read one byte at a time from a synchronous RAM with one cycle of read latency. The builder walks a global byte index and picks each byte's source from that index: seed, RAM or padding. It writes the bytes one by one into a 1088-bit block register. It then offers the finished block to a multi-block absorb port.

A `start` pulse samples the ciphertext length and begins a run. Each finished block is held on the absorb port with `blk_valid` until the port takes it. The builder then waits until the permutation has finished before it assembles the next block. The final block is marked with `blk_last`. When the sponge reports its digest, the builder latches the first 256 bits as the derived key and raises `done`.

Top module: `xof_block_builder`

## Requirements
- R1: After reset, `blk_valid`, `blk_last` and `done` are low and `key` is all zeros.
- R2: A byte with global index g (g = block number * 136 + byte position in block) below 32 equals seed byte g, which is `seed[8g+7:8g]`. Byte position p of a block sits at `blk_data[8p+7:8p]`.
- R3: A byte with 32 <= g < L comes from ciphertext RAM address g-32, where L = 32 + `ct_len`.
- R4: Padding puts 0x1F at g = L and 0x80 at the last byte of the final block. When these two positions are the same byte, that byte is 0x9F. Every other byte with g >= L is 0x00.
- R5: A run emits floor(L/136)+1 blocks. Ciphertext lengths of 768, 1088 and 1568 bytes give 6, 9 and 12 blocks.
- R6: `blk_last` is high only while the final block of a run is offered, and never without `blk_valid`.
- R7: `blk_valid` stays high and `blk_data` stays unchanged until the absorb port drops `blk_ready`. After that, the next block is not offered until `blk_ready` has returned high.
- R8: When `dig_valid` is seen after the final block, `key` takes `dig_data` on the next edge and `done` rises. `done` then stays high until the next `start`.
- R9: `start` clears `done` and `blk_valid` on the next edge and samples `ct_len`. Later changes to `ct_len` during the run do not alter the blocks that are emitted.
- R10: The RAM address is driven combinationally from the current index, and the returned byte is used one cycle later. The first ciphertext byte (g = 32), at the boundary with the seed, is therefore correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| ct_len | input | 11 | Ciphertext length in bytes, sampled at start |
| seed | input | 256 | 32-byte seed; byte i is bits [8i+7:8i] |
| ram_addr | output | 11 | Ciphertext RAM read address (combinational) |
| ram_data | input | 8 | RAM read data, valid one cycle after the address |
| blk_data | output | 1088 | Assembled rate block |
| blk_valid | output | 1 | Block offered to the absorb port |
| blk_last | output | 1 | Offered block is the final one |
| blk_ready | input | 1 | Absorb port idle; dropped once it takes a block |
| dig_valid | input | 1 | Final digest present |
| dig_data | input | 256 | First 256 bits of the squeezed output |
| key | output | 256 | Latched key |
| done | output | 1 | Run finished and key valid |

## Verification
The RAM byte for an address issued in one cycle is due in the next cycle, where it is written into the block. A full block therefore appears on `blk_valid` one cycle after its 136th address. The key and `done` follow one edge after the cycle in which `dig_valid` is seen. The bench's absorber model acts only on falling edges. It pops the expected block from a scoreboard queue at the moment it drops `blk_ready`. It reads `key` only after it has observed `done`. Before taking the first block of each run, it stalls for a few cycles and checks that the offered block does not change. This keeps every comparison inside the window in which the design holds the value.

// File: rtl/xbb_pkg.sv
package xbb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ASM,
    PH_FEED,
    PH_WAIT,
    PH_DONE
  } xbb_phase_e;

  typedef enum logic [1:0] {
    SRC_SEED,
    SRC_RAM,
    SRC_PAD
  } xbb_src_e;

  localparam logic [7:0] DOMAIN_PAD = 8'h1F;
  localparam logic [7:0] FINAL_PAD  = 8'h80;
endpackage

// File: rtl/xbb_len_calc.sv
module xbb_len_calc #(
  parameter int RATE_BYTES = 136,
  parameter int SEED_BYTES = 32,
  parameter int LEN_W      = 11,
  parameter int G_W        = 11,
  parameter int BLK_W      = 4
) (
  input  logic [LEN_W-1:0] ct_len,
  output logic [G_W-1:0]   msg_len,
  output logic [BLK_W-1:0] n_blocks,
  output logic [G_W-1:0]   last_g
);
  logic [G_W-1:0] full_blocks;

  always_comb begin
    msg_len     = G_W'(SEED_BYTES) + G_W'(ct_len);
    full_blocks = msg_len / G_W'(RATE_BYTES);
    n_blocks    = BLK_W'(full_blocks) + BLK_W'(1);
    last_g      = G_W'(n_blocks) * G_W'(RATE_BYTES) - G_W'(1);
  end
endmodule

// File: rtl/xbb_byte_plan.sv
module xbb_byte_plan
  import xbb_pkg::*;
#(
  parameter int SEED_BYTES = 32,
  parameter int G_W        = 11,
  parameter int ADDR_W     = 11,
  parameter int SI_W       = 5
) (
  input  logic [G_W-1:0]    g,
  input  logic [G_W-1:0]    msg_len,
  input  logic [G_W-1:0]    last_g,
  output xbb_src_e          src,
  output logic [7:0]        pad,
  output logic [SI_W-1:0]   seed_idx,
  output logic [ADDR_W-1:0] ram_addr
);
  always_comb begin
    if (g < G_W'(SEED_BYTES))  src = SRC_SEED;
    else if (g < msg_len)      src = SRC_RAM;
    else                       src = SRC_PAD;
    // domain byte and final-bit byte combine by OR when they coincide
    pad      = ((g == msg_len) ? DOMAIN_PAD : 8'h00) |
               ((g == last_g)  ? FINAL_PAD  : 8'h00);
    seed_idx = g[SI_W-1:0];
    ram_addr = ADDR_W'(g - G_W'(SEED_BYTES));
  end
endmodule

// File: rtl/xbb_lane_store.sv
module xbb_lane_store #(
  parameter int RATE_BYTES = 136,
  parameter int IDX_W      = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [7:0]              wdata,
  output logic [RATE_BYTES*8-1:0] block
);
  for (genvar i = 0; i < RATE_BYTES; i++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (we && idx == IDX_W'(i)) lane_q <= wdata;
    end
    assign block[i*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/xof_block_builder.sv
module xof_block_builder
  import xbb_pkg::*;
#(
  parameter int RATE_BYTES   = 136,
  parameter int SEED_BYTES   = 32,
  parameter int MAX_CT_BYTES = 1568,
  parameter int KEY_BITS     = 256
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [$clog2(MAX_CT_BYTES+1)-1:0]   ct_len,
  input  logic [SEED_BYTES*8-1:0]             seed,
  output logic [$clog2(MAX_CT_BYTES)-1:0]     ram_addr,
  input  logic [7:0]                          ram_data,
  output logic [RATE_BYTES*8-1:0]             blk_data,
  output logic                                blk_valid,
  output logic                                blk_last,
  input  logic                                blk_ready,
  input  logic                                dig_valid,
  input  logic [KEY_BITS-1:0]                 dig_data,
  output logic [KEY_BITS-1:0]                 key,
  output logic                                done
);
  localparam int LEN_W      = $clog2(MAX_CT_BYTES + 1);
  localparam int ADDR_W     = $clog2(MAX_CT_BYTES);
  localparam int MAX_BLOCKS = (SEED_BYTES + MAX_CT_BYTES) / RATE_BYTES + 1;
  localparam int BLK_W      = $clog2(MAX_BLOCKS + 1);
  localparam int G_W        = $clog2(MAX_BLOCKS * RATE_BYTES + 1);
  localparam int IDX_W      = $clog2(RATE_BYTES);
  localparam int CNT_W      = $clog2(RATE_BYTES + 1);
  localparam int SI_W       = $clog2(SEED_BYTES);

  xbb_phase_e       phase;
  logic [BLK_W-1:0] blk_cnt, nblk_r, nblk_c;
  logic [CNT_W-1:0] byte_cnt;
  logic [G_W-1:0]   msg_len_r, last_g_r, msg_len_c, last_g_c, g_cur;

  // pipeline stage between index issue and block write
  logic             wb_vld;
  logic [IDX_W-1:0] wb_idx;
  xbb_src_e         wb_src;
  logic [7:0]       wb_pad;
  logic [SI_W-1:0]  wb_sidx;

  xbb_src_e         pl_src;
  logic [7:0]       pl_pad, wr_byte;
  logic [SI_W-1:0]  pl_sidx;
  logic             final_blk;

  xbb_len_calc #(
    .RATE_BYTES(RATE_BYTES), .SEED_BYTES(SEED_BYTES),
    .LEN_W(LEN_W), .G_W(G_W), .BLK_W(BLK_W)
  ) u_len (
    .ct_len(ct_len), .msg_len(msg_len_c), .n_blocks(nblk_c), .last_g(last_g_c)
  );

  assign g_cur = G_W'(blk_cnt) * G_W'(RATE_BYTES) + G_W'(byte_cnt);

  xbb_byte_plan #(
    .SEED_BYTES(SEED_BYTES), .G_W(G_W), .ADDR_W(ADDR_W), .SI_W(SI_W)
  ) u_plan (
    .g(g_cur), .msg_len(msg_len_r), .last_g(last_g_r),
    .src(pl_src), .pad(pl_pad), .seed_idx(pl_sidx), .ram_addr(ram_addr)
  );

  always_comb begin
    case (wb_src)
      SRC_SEED: wr_byte = seed[wb_sidx*8 +: 8];
      SRC_RAM:  wr_byte = ram_data;
      default:  wr_byte = wb_pad;
    endcase
  end

  xbb_lane_store #(.RATE_BYTES(RATE_BYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(wb_vld && phase == PH_ASM), .idx(wb_idx),
    .wdata(wr_byte), .block(blk_data)
  );

  assign final_blk = (blk_cnt == nblk_r - BLK_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      blk_cnt   <= '0;
      byte_cnt  <= '0;
      nblk_r    <= '0;
      msg_len_r <= '0;
      last_g_r  <= '0;
      wb_vld    <= 1'b0;
      wb_idx    <= '0;
      wb_src    <= SRC_PAD;
      wb_pad    <= '0;
      wb_sidx   <= '0;
      blk_valid <= 1'b0;
      blk_last  <= 1'b0;
      key       <= '0;
      done      <= 1'b0;
    end else if (start) begin
      phase     <= PH_ASM;
      blk_cnt   <= '0;
      byte_cnt  <= '0;
      nblk_r    <= nblk_c;
      msg_len_r <= msg_len_c;
      last_g_r  <= last_g_c;
      wb_vld    <= 1'b0;
      blk_valid <= 1'b0;
      blk_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (phase)
        PH_ASM: begin
          if (byte_cnt < CNT_W'(RATE_BYTES)) begin
            wb_vld   <= 1'b1;
            wb_idx   <= IDX_W'(byte_cnt);
            wb_src   <= pl_src;
            wb_pad   <= pl_pad;
            wb_sidx  <= pl_sidx;
            byte_cnt <= byte_cnt + CNT_W'(1);
          end else begin
            wb_vld    <= 1'b0;
            byte_cnt  <= '0;
            blk_valid <= 1'b1;
            blk_last  <= final_blk;
            phase     <= PH_FEED;
          end
        end
        PH_FEED: begin
          if (!blk_ready) begin
            blk_valid <= 1'b0;
            blk_last  <= 1'b0;
            phase     <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (dig_valid) begin
            key   <= dig_data;
            done  <= 1'b1;
            phase <= PH_DONE;
          end else if (blk_ready && !final_blk) begin
            blk_cnt <= blk_cnt + BLK_W'(1);
            phase   <= PH_ASM;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xbb_checker.sv
module xbb_checker #(
  parameter int RATE_BYTES = 136
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic [RATE_BYTES*8-1:0] blk_data,
  input logic                    blk_valid,
  input logic                    blk_last,
  input logic                    blk_ready,
  input logic                    dig_valid,
  input logic                    done
);
  // R6
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    blk_last |-> blk_valid);

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_ready && !start) |=> blk_valid);

  // R7
  data_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !start) |=> (!blk_valid || $stable(blk_data)));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(dig_valid));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && !blk_valid));
endmodule

bind xof_block_builder xbb_checker #(.RATE_BYTES(RATE_BYTES)) u_xbb_chk (
  .clk(clk), .rst(rst), .start(start), .blk_data(blk_data),
  .blk_valid(blk_valid), .blk_last(blk_last), .blk_ready(blk_ready),
  .dig_valid(dig_valid), .done(done)
);

// File: tb/xof_block_builder_test.sv
module xof_block_builder_test;
  localparam int RATE = 136;
  localparam int SEEDB = 32;
  localparam int PERM = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [10:0] ct_len = '0;
  logic [255:0] seed = '0;
  logic [10:0] ram_addr;
  logic [7:0] ram_data;
  logic [1087:0] blk_data;
  logic blk_valid, blk_last;
  logic blk_ready = 1'b1;
  logic dig_valid = 1'b0;
  logic [255:0] dig_data = '0;
  logic [255:0] key;
  logic done;

  xof_block_builder uut (
    .clk(clk), .rst(rst), .start(start), .ct_len(ct_len), .seed(seed),
    .ram_addr(ram_addr), .ram_data(ram_data), .blk_data(blk_data),
    .blk_valid(blk_valid), .blk_last(blk_last), .blk_ready(blk_ready),
    .dig_valid(dig_valid), .dig_data(dig_data), .key(key), .done(done)
  );

  always #10 clk = ~clk;

  logic [7:0] ct_mem [0:2047];
  always @(posedge clk) ram_data <= ct_mem[ram_addr];

  int checks = 0, failures = 0, cyc = 0;
  bit timed_out = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) timed_out <= 1'b1;
  end

  // scoreboard state
  logic [1087:0] exp_q[$];
  logic [1087:0] snap, expb;
  int cur_msglen, cur_nblk, blk_seen, perm_cnt, stall_left;
  int err_seed, err_ram, err_pad, last_err, stall_bad, q_empty_err;
  bit pending_last, boundary_ok;
  logic [255:0] exp_key;
  logic [7:0] a_byte, e_byte, first_act, first_exp;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // absorber model: acts on falling edges only
  always @(negedge clk) begin
    if (!rst) begin
      dig_valid = 1'b0;
      if (perm_cnt > 0) begin
        perm_cnt--;
        if (perm_cnt == 0) begin
          if (pending_last) dig_valid = 1'b1;
          blk_ready = 1'b1;
        end
      end else if (blk_valid && blk_ready) begin
        if (stall_left > 0) begin
          if (stall_left == 3) snap = blk_data;
          else if (blk_data !== snap) stall_bad++;
          stall_left--;
        end else begin
          if (exp_q.size() == 0) begin
            q_empty_err++;
            expb = '0;
          end else expb = exp_q.pop_front();
          for (int i = 0; i < RATE; i++) begin
            int g;
            g = blk_seen * RATE + i;
            a_byte = blk_data[i*8 +: 8];
            e_byte = expb[i*8 +: 8];
            if (g == SEEDB && cur_msglen > SEEDB) boundary_ok = (a_byte === e_byte);
            if (a_byte !== e_byte) begin
              if (err_seed + err_ram + err_pad == 0) begin
                first_act = a_byte;
                first_exp = e_byte;
              end
              if (g < SEEDB) err_seed++;
              else if (g < cur_msglen) err_ram++;
              else err_pad++;
            end
          end
          if (blk_last !== (blk_seen == cur_nblk - 1)) last_err++;
          pending_last = blk_last;
          blk_seen++;
          blk_ready = 1'b0;
          perm_cnt = PERM;
        end
      end
    end
  end

  task automatic run_case(input int len, input logic [255:0] sd, input bit wiggle);
    logic [1087:0] b;
    int g;
    for (int a = 0; a < len; a++) ct_mem[a] = 8'((a * 13 + len * 3 + 7) & 255);
    seed = sd;
    cur_msglen = SEEDB + len;
    cur_nblk = cur_msglen / RATE + 1;
    exp_q.delete();
    for (int bi = 0; bi < cur_nblk; bi++) begin
      for (int i = 0; i < RATE; i++) begin
        g = bi * RATE + i;
        if (g < SEEDB) b[i*8 +: 8] = sd[g*8 +: 8];
        else if (g < cur_msglen) b[i*8 +: 8] = ct_mem[g - SEEDB];
        else begin
          b[i*8 +: 8] = 8'h00;
          if (g == cur_msglen) b[i*8 +: 8] = b[i*8 +: 8] | 8'h1F;
          if (g == cur_nblk * RATE - 1) b[i*8 +: 8] = b[i*8 +: 8] | 8'h80;
        end
      end
      exp_q.push_back(b);
    end
    exp_key = {8{32'(len) ^ 32'hC3A5_0F00}};
    dig_data = exp_key;
    blk_seen = 0; err_seed = 0; err_ram = 0; err_pad = 0; last_err = 0;
    stall_bad = 0; q_empty_err = 0; stall_left = 3; boundary_ok = 1'b0;
    @(negedge clk);
    ct_len = 11'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: start clears done and valid on the next edge
    chk(!done && !blk_valid, "R9", "start clears flags", {254'd0, done, blk_valid}, 256'd0);
    if (wiggle) ct_len = 11'd500;
    while (!done && !timed_out) @(negedge clk);
    chk(blk_seen == cur_nblk && q_empty_err == 0, "R5", $sformatf("block count len=%0d", len),
        256'(blk_seen), 256'(cur_nblk));
    chk(last_err == 0, "R6", "last flag on final block only", 256'(last_err), 256'd0);
    chk(err_seed == 0, "R2", "seed bytes", {248'd0, first_act}, {248'd0, first_exp});
    if (len > 0) begin
      chk(err_ram == 0, "R3", "ciphertext bytes", {248'd0, first_act}, {248'd0, first_exp});
      chk(boundary_ok, "R10", "first ciphertext byte at g=32", 256'(boundary_ok), 256'd1);
    end
    chk(err_pad == 0, "R4", $sformatf("pad bytes len=%0d", len), {248'd0, first_act}, {248'd0, first_exp});
    chk(stall_bad == 0, "R7", "block held while ready high", 256'(stall_bad), 256'd0);
    chk(key === exp_key && done, "R8", "key latched from digest", key, exp_key);
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R8", "done held", 256'(done), 256'd1);
    if (wiggle) chk(blk_seen == cur_nblk, "R9", "length change mid-run ignored",
                    256'(blk_seen), 256'(cur_nblk));
  endtask

  initial begin
    perm_cnt = 0;
    pending_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!blk_valid && !blk_last && !done, "R1", "flags after reset",
        {253'd0, blk_valid, blk_last, done}, 256'd0);
    chk(key === '0, "R1", "key after reset", key, 256'd0);
    run_case(768,  {8{32'h0123_4567}}, 1'b0);
    run_case(1088, {8{32'h89AB_CDEF}}, 1'b1);
    run_case(1568, {8{32'h5A5A_1234}}, 1'b0);
    run_case(103,  {8{32'hDEAD_BEEF}}, 1'b0);  // R4: 0x9F case
    run_case(104,  {8{32'h0F0F_F0F0}}, 1'b0);  // R4: pad-only block
    run_case(0,    {8{32'h1357_9BDF}}, 1'b0);
    if (timed_out) chk(1'b0, "WDOG", "watchdog expired", 256'(cyc), 256'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule